// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block sits beside a parallel, asynchronous-style memory interface and watches the reads that reach it. The bus pins are sampled on the system clock. Two commands are hidden in the address stream as exact runs of six reads. One run asks for the memory contents to be saved to nonvolatile storage (a store). The other asks for them to be brought back (a recall). When a run is complete, the block raises a one-cycle request on the matching output. A separate store controller picks up that request and carries out the transfer.

Both commands begin with the same three reads. The last three reads of the recall command are set by parameters. The command is encoded only by the order of the read addresses. A write anywhere, or a read of any address that is not the next expected one, throws away the partial match. While the controller reports that it is busy, the block ignores all bus traffic and holds its progress at zero. A 3-bit progress output shows how many reads of a command have matched so far.

Top module: `addr_seq_detector`

## Requirements
- R1: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F, in that order and with nothing in between, make `store_req` high for exactly one clock cycle. `seq_step` returns to 0 in that same cycle.
- R2: Reads of 0x0000, 0x1555, 0x0AAA and then the three parameter addresses (defaults 0x1FFF, 0x10F0, 0x0E0F), in that order and with nothing in between, make `recall_req` high for exactly one clock cycle. `seq_step` returns to 0 in that same cycle.
- R3: A read is counted when the sampled condition (`ce_n` low and `we_n` high) becomes true. The level of `oe_n` does not need to be low for the read to count.
- R4: While `ce_n` stays low and `we_n` stays high, each high-to-low transition of `oe_n` counts as one new read of the address present at that time.
- R5: A write (`ce_n` and `we_n` both low) clears the progress to 0. No request is issued.
- R6: A read of an address other than the next expected one cancels the partial match and no request is issued. If that read is of 0x0000, progress becomes 1; otherwise it becomes 0.
- R7: While `busy` is high, reads and writes are ignored, progress is forced to 0 and neither request is raised.
- R8: `seq_step` gives the number of reads matched so far in the current run, from 0 to 5. It changes only by going up by one, by dropping to 0, or by dropping to 1 on a restart.
- R9: After reset, `store_req` and `recall_req` are low and `seq_step` is 0.
- R10: A read held for many cycles counts only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 13 | Bus address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Store controller busy; bus traffic is ignored while high |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |
| seq_step | output | 3 | Number of reads matched in the current run |

## Verification
The bus pins pass through one sampling register, and the tracker register follows it. A read or write that starts before clock edge k therefore updates `seq_step` and any request pulse at edge k+1, which is two rising edges after the bus change. The bench drives inputs on falling edges and counts request pulses on every falling edge. It compares `seq_step` and the pulse counts against its reference model only after each access has been followed by at least two idle cycles. At that point every result of the access has settled, and any pulse that lasted more than one cycle would have been counted twice. `busy` is applied before an access begins and removed only after that access's idle cycles, so it is in effect at the edge where the access would have been acted on.

// File: rtl/seqdet_pkg.sv
// Package: shared widths, the fixed store key addresses and the
// bus event type used between the sampler and the tracker.
package seqdet_pkg;

    localparam int unsigned ADDR_W     = 13;
    localparam int unsigned SEQ_LEN    = 6;
    localparam int unsigned STEP_W     = $clog2(SEQ_LEN + 1);
    localparam int unsigned LAST_STEP  = SEQ_LEN - 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    // Keys shared by both commands (first three reads)
    localparam addr_t KEY_A = 13'h0000;
    localparam addr_t KEY_B = 13'h1555;
    localparam addr_t KEY_C = 13'h0AAA;
    // Tail of the store command
    localparam addr_t STORE_D = 13'h1FFF;
    localparam addr_t STORE_E = 13'h10F0;
    localparam addr_t STORE_F = 13'h0F0F;

    // One decoded bus access, valid for a single cycle
    typedef struct packed {
        logic rd;
        logic wr;
    } bus_evt_t;

endpackage

// File: rtl/seqdet_bus_sampler.sv
// Module: seqdet_bus_sampler
// Samples the asynchronous-style bus pins on clk and turns them into
// single-cycle read and write events. A read event is the rise of
// (ce low and we high), or a falling oe while that condition holds.
// A write event is the rise of (ce low and we low).
// Assumes: the pins are stable around the clock edges, so one
// register stage is enough. Events are valid one edge after the
// bus change.
module seqdet_bus_sampler
    import seqdet_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  addr_t    addr_i,
    input  logic     ce_n_i,
    input  logic     we_n_i,
    input  logic     oe_n_i,
    output addr_t    addr_o,
    output bus_evt_t evt_o
);

    logic rd_lvl, rd_lvl_q;
    logic wr_lvl, wr_lvl_q;
    logic oe_lvl, oe_lvl_q;
    addr_t addr_s;

    // Sample the pins and keep the previous sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lvl   <= 1'b0;
            wr_lvl   <= 1'b0;
            oe_lvl   <= 1'b0;
            rd_lvl_q <= 1'b0;
            wr_lvl_q <= 1'b0;
            oe_lvl_q <= 1'b0;
            addr_s   <= '0;
        end else begin
            rd_lvl   <= ~ce_n_i & we_n_i;
            wr_lvl   <= ~ce_n_i & ~we_n_i;
            oe_lvl   <= ~oe_n_i;
            rd_lvl_q <= rd_lvl;
            wr_lvl_q <= wr_lvl;
            oe_lvl_q <= oe_lvl;
            addr_s   <= addr_i;
        end
    end

    // Decode the edges into one-cycle events
    always_comb begin
        evt_o.rd = rd_lvl & (~rd_lvl_q | (oe_lvl & ~oe_lvl_q));
        evt_o.wr = wr_lvl & ~wr_lvl_q;
    end

    assign addr_o = addr_s;

endmodule

// File: rtl/seqdet_key_match.sv
// Module: seqdet_key_match
// Compares the sampled address against every key of one command and
// picks out the comparison for the current step.
// Assumes: KEYS packs SEQ_LEN addresses, with step 0 in the low bits.
module seqdet_key_match
    import seqdet_pkg::*;
#(
    parameter logic [SEQ_LEN*ADDR_W-1:0] KEYS = '0
)
(
    input  addr_t addr_i,
    input  step_t step_i,
    output logic  hit_o,
    output logic  first_hit_o
);

    logic [SEQ_LEN-1:0] hit_vec;

    // One comparator per position in the command
    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_cmp
        assign hit_vec[g] = (addr_i == KEYS[g*ADDR_W +: ADDR_W]);
    end

    // Select the comparator for the step being waited on
    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < SEQ_LEN; i++) begin
            if (step_i == step_t'(i)) hit_o = hit_vec[i];
        end
    end

    assign first_hit_o = hit_vec[0];

endmodule

// File: rtl/seqdet_tracker.sv
// Module: seqdet_tracker
// Keeps the progress count and one "still possible" flag for each
// command. Issues one-cycle requests when the last read matches.
// Assumes: rd and wr are never both high. busy is used at the edge
// where it is seen, with no register in between.
module seqdet_tracker
    import seqdet_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy_i,
    input  bus_evt_t evt_i,
    input  logic     store_hit_i,
    input  logic     recall_hit_i,
    input  logic     first_hit_i,
    output step_t    step_o,
    output logic     store_o,
    output logic     recall_o
);

    step_t step_r;
    logic  store_live, recall_live;
    logic  store_ok, recall_ok, last_step;

    // Which commands can still accept this read
    always_comb begin
        store_ok  = store_live & store_hit_i;
        recall_ok = recall_live & recall_hit_i;
        last_step = (step_r == step_t'(LAST_STEP));
    end

    // Move the progress state forward, cancel it or restart it, and fire requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_r      <= '0;
            store_live  <= 1'b1;
            recall_live <= 1'b1;
            store_o     <= 1'b0;
            recall_o    <= 1'b0;
        end else begin
            store_o  <= 1'b0;
            recall_o <= 1'b0;
            if (busy_i || evt_i.wr) begin
                step_r      <= '0;
                store_live  <= 1'b1;
                recall_live <= 1'b1;
            end else if (evt_i.rd) begin
                if (store_ok || recall_ok) begin
                    if (last_step) begin
                        store_o     <= store_ok;
                        recall_o    <= recall_ok;
                        step_r      <= '0;
                        store_live  <= 1'b1;
                        recall_live <= 1'b1;
                    end else begin
                        step_r      <= step_r + step_t'(1);
                        store_live  <= store_ok;
                        recall_live <= recall_ok;
                    end
                end else begin
                    step_r      <= first_hit_i ? step_t'(1) : '0;
                    store_live  <= 1'b1;
                    recall_live <= 1'b1;
                end
            end
        end
    end

    assign step_o = step_r;

endmodule

// File: rtl/addr_seq_detector.sv
// Module: addr_seq_detector (top)
// Recognises the store and recall commands hidden in the order of
// read addresses, and issues one-cycle request pulses.
// Assumes: a store controller raises busy while it transfers data.
// Results appear two clock edges after the bus access begins.
module addr_seq_detector
    import seqdet_pkg::*;
#(
    parameter addr_t RCL_KEY_D = 13'h1FFF,
    parameter addr_t RCL_KEY_E = 13'h10F0,
    parameter addr_t RCL_KEY_F = 13'h0E0F
)
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [12:0] addr,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic        busy,
    output logic        store_req,
    output logic        recall_req,
    output logic [2:0]  seq_step
);

    localparam logic [SEQ_LEN*ADDR_W-1:0] STORE_KEYS =
        {STORE_F, STORE_E, STORE_D, KEY_C, KEY_B, KEY_A};
    localparam logic [SEQ_LEN*ADDR_W-1:0] RECALL_KEYS =
        {RCL_KEY_F, RCL_KEY_E, RCL_KEY_D, KEY_C, KEY_B, KEY_A};

    addr_t    addr_s;
    bus_evt_t evt;
    step_t    step;
    logic     store_hit, recall_hit, first_hit, first_hit_unused;

    seqdet_bus_sampler u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr),
        .ce_n_i (ce_n),
        .we_n_i (we_n),
        .oe_n_i (oe_n),
        .addr_o (addr_s),
        .evt_o  (evt)
    );

    seqdet_key_match #(.KEYS(STORE_KEYS)) u_store_match (
        .addr_i      (addr_s),
        .step_i      (step),
        .hit_o       (store_hit),
        .first_hit_o (first_hit)
    );

    seqdet_key_match #(.KEYS(RECALL_KEYS)) u_recall_match (
        .addr_i      (addr_s),
        .step_i      (step),
        .hit_o       (recall_hit),
        .first_hit_o (first_hit_unused)
    );

    seqdet_tracker u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy),
        .evt_i        (evt),
        .store_hit_i  (store_hit),
        .recall_hit_i (recall_hit),
        .first_hit_i  (first_hit | first_hit_unused),
        .step_o       (step),
        .store_o      (store_req),
        .recall_o     (recall_req)
    );

    assign seq_step = step;

endmodule

// File: rtl/seqdet_checker.sv
// Module: seqdet_checker
// Properties on the ports of addr_seq_detector, attached with bind.
module seqdet_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       store_req,
    input logic       recall_req,
    input logic [2:0] seq_step
);

    AST_STORE_AFTER_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> ($past(seq_step) == 3'd5 && seq_step == 3'd0)); // R1
    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R1
    AST_RECALL_AFTER_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> ($past(seq_step) == 3'd5 && seq_step == 3'd0)); // R2
    AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req); // R2
    AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (seq_step == 3'd0 && !store_req && !recall_req)); // R7
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_step <= 3'd5); // R8
    AST_STEP_MOVES_LEGALLY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step != $past(seq_step)) |->
            (seq_step <= 3'd1 || seq_step == $past(seq_step) + 3'd1)); // R8

endmodule

bind addr_seq_detector seqdet_checker u_seqdet_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .store_req  (store_req),
    .recall_req (recall_req),
    .seq_step   (seq_step)
);

// File: tb/addr_seq_detector_tb.sv
module addr_seq_detector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        busy = 1'b0;
    logic        store_req, recall_req;
    logic [2:0]  seq_step;

    int n_chk = 0;
    int n_bad = 0;
    int store_seen = 0;
    int recall_seen = 0;
    int exp_store = 0;
    int exp_recall = 0;
    int m_step = 0;
    bit m_sl = 1'b1;
    bit m_rl = 1'b1;
    bit done = 1'b0;

    logic [12:0] skey [6] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, 13'h0F0F};
    logic [12:0] rkey [6] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, 13'h0E0F};

    always #10 clk = ~clk;

    addr_seq_detector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .busy       (busy),
        .store_req  (store_req),
        .recall_req (recall_req),
        .seq_step   (seq_step)
    );

    // Count request pulses, one count per cycle they are high
    always @(negedge clk) begin
        if (rst_n) begin
            if (store_req)  store_seen++;
            if (recall_req) recall_seen++;
        end
    end

    function automatic void model_clear();
        m_step = 0; m_sl = 1'b1; m_rl = 1'b1;
    endfunction

    // Reference behaviour of one counted read, written from R1, R2 and R6
    function automatic void model_read(input logic [12:0] a);
        bit sok, rok;
        sok = m_sl && (a == skey[m_step]);
        rok = m_rl && (a == rkey[m_step]);
        if (sok || rok) begin
            if (m_step == 5) begin
                if (sok) exp_store++;
                if (rok) exp_recall++;
                model_clear();
            end else begin
                m_step++; m_sl = sok; m_rl = rok;
            end
        end else begin
            model_clear();
            if (a == 13'h0000) m_step = 1;
        end
    endfunction

    task automatic check(input string req);
        #1;
        n_chk++;
        if (seq_step != 3'(m_step) || store_seen != exp_store || recall_seen != exp_recall) begin
            n_bad++;
            $display("FAIL %s: step=%0d store=%0d recall=%0d, expected step=%0d store=%0d recall=%0d",
                     req, seq_step, store_seen, recall_seen, m_step, exp_store, exp_recall);
        end
    endtask

    // CE-framed read held for hold cycles; oe_n level chosen by caller
    task automatic do_read(input logic [12:0] a, input int hold, input logic oe_lvl, input bit bsy);
        @(negedge clk);
        busy = bsy;
        addr = a; we_n = 1'b1; oe_n = oe_lvl; ce_n = 1'b0;
        repeat (hold) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
        busy = 1'b0;
        if (bsy) model_clear(); else model_read(a);
    endtask

    task automatic do_write(input logic [12:0] a);
        @(negedge clk);
        addr = a; we_n = 1'b0; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (2) @(negedge clk);
        model_clear();
    endtask

    // OE-framed burst: CE stays low, each falling oe_n is a read
    task automatic oe_burst(input logic [12:0] k [6]);
        @(negedge clk);
        addr = k[0]; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        model_read(k[0]);
        for (int i = 1; i < 6; i++) begin
            oe_n = 1'b1; addr = k[i];
            @(negedge clk);
            oe_n = 1'b0;
            repeat (2) @(negedge clk);
            model_read(k[i]);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_seq(input logic [12:0] k [6], input string req);
        for (int i = 0; i < 6; i++) begin
            do_read(k[i], 2, 1'b1, 1'b0);
            check(req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset state");

        run_seq(skey, "R1 store sequence, R8 progress");
        run_seq(rkey, "R2 recall sequence, R8 progress");

        // R3: oe_n held low during CE-framed reads still counts
        for (int i = 0; i < 6; i++) do_read(skey[i], 2, 1'b0, 1'b0);
        check("R3 read with oe low");

        oe_burst(skey);
        check("R4 oe framed store");
        oe_burst(rkey);
        check("R4 oe framed recall");

        for (int i = 0; i < 4; i++) do_read(skey[i], 2, 1'b1, 1'b0);
        do_write(13'h1234);
        check("R5 write aborts");
        for (int i = 4; i < 6; i++) do_read(skey[i], 2, 1'b1, 1'b0);
        check("R5 no request after abort");

        for (int i = 0; i < 3; i++) do_read(skey[i], 2, 1'b1, 1'b0);
        do_read(13'h0123, 2, 1'b1, 1'b0);
        check("R6 wrong read aborts to 0");
        for (int i = 0; i < 4; i++) do_read(skey[i], 2, 1'b1, 1'b0);
        do_read(13'h0000, 2, 1'b1, 1'b0);
        check("R6 restart at step 1");
        for (int i = 1; i < 6; i++) do_read(skey[i], 2, 1'b1, 1'b0);
        check("R6 store after restart");

        for (int i = 0; i < 3; i++) do_read(skey[i], 2, 1'b1, 1'b0);
        do_read(skey[3], 2, 1'b1, 1'b1);
        check("R7 busy clears and ignores");
        for (int i = 4; i < 6; i++) do_read(skey[i], 2, 1'b1, 1'b0);
        check("R7 no request after busy");

        for (int i = 0; i < 6; i++) do_read(rkey[i], 7, 1'b1, 1'b0);
        check("R10 long reads count once");

        // Random mix, addresses biased toward the next key of either command
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            logic [12:0] a;
            r = $urandom % 10;
            if ($urandom % 4 != 0) a = ($urandom % 2) ? skey[m_step] : rkey[m_step];
            else a = 13'($urandom);
            if (r == 0)      do_write(a);
            else if (r == 1) do_read(a, 2, 1'b1, 1'b1);
            else             do_read(a, 1 + ($urandom % 3), 1'($urandom), 1'b0);
            check("R1 R2 R5 R6 R7 R8 random mix");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule